// File: doc/BRIEF.md
# Transmit Holding Empty Interrupt Generator

This block raises the "transmit holding FIFO empty" interrupt request of a FIFO-based serial transmitter. It watches the FIFO occupancy and, whenever the FIFO turns empty, decides how soon to raise the request. If software has recently kept the FIFO at two or more characters, the FIFO is assumed to be in steady use and the request rises at once. If not, as at start-up or after single-character writes, the request is held back for one character time minus the stop bit. This gives software time to write the next character before an interrupt has to be decoded and serviced.

The request is cleared by a write to the transmit holding register, or by a read of the interrupt identification register when the surrounding priority logic reports that this source was the highest one pending. In that priority scheme the source sits at third level. The FIFO, the serial shifter and the priority encoder live outside. All pins are plain control and status signals. Nothing streams through the block, so there is no valid/ready interface.

Top module: `thre_irq_gen`

## Requirements
- R1: While reset (`rst_n` low) is asserted and in the cycle after it is released, `thre_irq` is low.
- R2: When `fifo_count` turns zero (an empty event) and the FIFO held two or more characters at one time since the previous empty event, `thre_irq` rises on the clock edge that samples the zero count.
- R3: When an empty event occurs without that history, `thre_irq` rises on the edge that samples the N-th `bit_tick` after the event, where N = start + data + parity bits. The frame setting is captured at the event, so later changes do not alter the delay.
- R4: The "two or more held" history sets whenever `fifo_count` >= 2 and clears at every empty event. A second empty event with no refill to two characters is therefore delayed again.
- R5: A `thr_wr` pulse clears `thre_irq` on the next edge and cancels any delay in progress, so no request follows from that delay.
- R6: An `iir_rd` pulse with `iir_thre_top` high clears `thre_irq`. With `iir_thre_top` low it has no effect.
- R7: A clear (R5 or R6) in the same cycle as a set condition wins, and `thre_irq` stays low.
- R8: After reset, an already empty FIFO counts as a fresh empty event with the delay applied.
- R9: If `fifo_count` becomes non-zero during a delay, the delay is abandoned. The next zero count starts a full new delay.
- R10: Frame length encoding: `char_len` 0,1,2,3 selects 5,6,7,8 data bits, and `parity_en` = 1 adds one bit. This gives N from 6 to 10.
- R11: After an identification-register read clears the request while the FIFO stays empty, `thre_irq` stays low until the next empty event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Interrupt identification register read strobe |
| iir_thre_top | input | 1 | This source is the highest pending one at that read |
| bit_tick | input | 1 | One pulse per serial bit time |
| char_len | input | 2 | Data bits code, 0 to 3 for 5 to 8 bits |
| parity_en | input | 1 | Parity bit present in the frame |
| thre_irq | output | 1 | Registered interrupt request |

## Verification
Every result appears after exactly one clock edge. An immediate request shows after the edge that samples the zero count. A delayed request shows after the edge that samples the N-th tick. A clear shows after the edge that samples the strobe. The bench drives inputs on falling edges and samples one falling edge later, so each check lands right after the edge that owns it. Delayed cases are checked both one tick early (low) and on the exact tick (high). This is done for all eight frame settings.

// File: rtl/thre_pkg.sv
package thre_pkg;

  typedef enum logic [1:0] {
    LEN_5 = 2'd0,
    LEN_6 = 2'd1,
    LEN_7 = 2'd2,
    LEN_8 = 2'd3
  } char_len_e;

  // bits sent before the stop bit: start + data + optional parity
  function automatic int unsigned pre_stop_bits(int unsigned min_data,
                                                int unsigned len_code,
                                                logic parity);
    return 1 + min_data + len_code + (parity ? 1 : 0);
  endfunction

endpackage

// File: rtl/thre_empty_track.sv
module thre_empty_track #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             empty,
  output logic             empty_evt,
  output logic             seen_two
);

  logic empty_q;

  assign empty     = (fifo_count == '0);
  // empty_q resets low so an empty FIFO after reset is a fresh event
  assign empty_evt = empty && !empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q  <= 1'b0;
      seen_two <= 1'b0;
    end else begin
      empty_q <= empty;
      if (empty_evt)
        seen_two <= 1'b0;
      else if (fifo_count >= CNT_W'(2))
        seen_two <= 1'b1;
    end
  end

  assert_history_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |=> !seen_two);

  assert_history_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count >= CNT_W'(2)) |=> seen_two);

endmodule

// File: rtl/thre_delay_timer.sv
module thre_delay_timer #(
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic [TMR_W-1:0] target,
  output logic             busy,
  output logic             done
);

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] tgt_q;

  assign done = busy && tick && !abort && ((cnt + TMR_W'(1)) == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      tgt_q <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= '0;
      tgt_q <= target;
    end else if (busy && tick) begin
      if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + TMR_W'(1);
      end
    end
  end

  assert_count_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < tgt_q));

  assert_done_ends_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

endmodule

// File: rtl/thre_irq_flag.sv
module thre_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq <= 1'b0;
    else if (clear)
      irq <= 1'b0;
    else if (set)
      irq <= 1'b1;
  end

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !irq);

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clear) |=> irq);

endmodule

// File: rtl/thre_irq_gen.sv
module thre_irq_gen #(
  parameter int FIFO_DEPTH = 16,
  parameter int MIN_DATA   = 5,
  parameter int LEN_W      = 2,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int MAX_BITS  = 1 + MIN_DATA + (1 << LEN_W) - 1 + 1,
  localparam int TMR_W     = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             iir_thre_top,
  input  logic             bit_tick,
  input  logic [LEN_W-1:0] char_len,
  input  logic             parity_en,
  output logic             thre_irq
);

  import thre_pkg::*;

  logic             empty;
  logic             empty_evt;
  logic             seen_two;
  logic             tmr_busy;
  logic             tmr_done;
  logic             tmr_abort;
  logic             tmr_start;
  logic             irq_set;
  logic             irq_clear;
  logic [TMR_W-1:0] frame_target;

  assign frame_target = TMR_W'(pre_stop_bits(MIN_DATA, int'(char_len), parity_en));

  thre_empty_track #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .empty      (empty),
    .empty_evt  (empty_evt),
    .seen_two   (seen_two)
  );

  // a write or a refilled FIFO cancels a pending delay
  assign tmr_abort = thr_wr || !empty;
  assign tmr_start = empty_evt && !seen_two;

  thre_delay_timer #(.TMR_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .abort  (tmr_abort),
    .tick   (bit_tick),
    .target (frame_target),
    .busy   (tmr_busy),
    .done   (tmr_done)
  );

  assign irq_set   = (empty_evt && seen_two) || tmr_done;
  assign irq_clear = thr_wr || (iir_rd && iir_thre_top);

  thre_irq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_set),
    .clear (irq_clear),
    .irq   (thre_irq)
  );

  assert_rise_only_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thre_irq) |-> ($past(fifo_count) == '0));

  assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_irq);

  assert_read_top_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_thre_top) |=> !thre_irq);

  assert_read_not_top_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_irq && iir_rd && !iir_thre_top && !thr_wr) |=> thre_irq);

  assert_no_delay_when_busy_flag_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |-> empty);

endmodule

// File: tb/thre_irq_gen_test.sv
module thre_irq_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fifo_count = 5'd0;
  logic       thr_wr = 1'b0;
  logic       iir_rd = 1'b0;
  logic       iir_thre_top = 1'b0;
  logic       bit_tick = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       parity_en = 1'b1;
  logic       thre_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  thre_irq_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_count   (fifo_count),
    .thr_wr       (thr_wr),
    .iir_rd       (iir_rd),
    .iir_thre_top (iir_thre_top),
    .bit_tick     (bit_tick),
    .char_len     (char_len),
    .parity_en    (parity_en),
    .thre_irq     (thre_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s thre_irq actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int frame_n(input int len, input int par);
    return 1 + 5 + len + par;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_pulse;
    thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  // peak occupancy for one cycle, then zero; returns after the event edge
  task automatic empty_after(input int peak);
    fifo_count = 5'(peak);
    @(negedge clk);
    fifo_count = 5'd0;
    @(negedge clk);
  endtask

  task automatic delay_check(input string req, input int n);
    repeat (n - 1) tick();
    chk(req, thre_irq, 1'b0);
    tick();
    chk(req, thre_irq, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 / R8: reset with empty FIFO, 8 data bits + parity
    idle(3);
    chk("R1", thre_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", thre_irq, 1'b0);
    delay_check("R8", frame_n(3, 1));

    // R6: read while not top keeps it, read while top clears it
    iir_rd = 1'b1; iir_thre_top = 1'b0;
    @(negedge clk);
    iir_rd = 1'b0;
    chk("R6", thre_irq, 1'b1);
    iir_rd = 1'b1; iir_thre_top = 1'b1;
    @(negedge clk);
    iir_rd = 1'b0; iir_thre_top = 1'b0;
    chk("R6", thre_irq, 1'b0);
    // R11: stays low while empty, no new event
    repeat (12) tick();
    chk("R11", thre_irq, 1'b0);

    // R3 / R10: all frame settings, setting changed mid-delay
    for (int len = 0; len < 4; len++) begin
      for (int par = 0; par < 2; par++) begin
        char_len = 2'(len);
        parity_en = par[0];
        empty_after(1);
        chk("R3", thre_irq, 1'b0);
        char_len = 2'(len + 1);
        parity_en = ~par[0];
        delay_check("R10", frame_n(len, par));
        wr_pulse();
        chk("R5", thre_irq, 1'b0);
      end
    end

    // R2: immediate request for peaks of two or more
    char_len = 2'd0; parity_en = 1'b0;
    for (int pk = 2; pk < 6; pk++) begin
      empty_after(pk);
      chk("R2", thre_irq, 1'b1);
      wr_pulse();
      chk("R5", thre_irq, 1'b0);
    end

    // R4: history cleared by the event, next single-char empty delayed
    empty_after(3);
    chk("R4", thre_irq, 1'b1);
    wr_pulse();
    empty_after(1);
    chk("R4", thre_irq, 1'b0);
    delay_check("R4", frame_n(0, 0));
    wr_pulse();

    // R5: write during delay aborts it
    empty_after(1);
    repeat (3) tick();
    wr_pulse();
    repeat (12) tick();
    chk("R5", thre_irq, 1'b0);

    // R9: refill during delay abandons it, next zero restarts in full
    empty_after(1);
    repeat (3) tick();
    fifo_count = 5'd1;
    repeat (12) tick();
    chk("R9", thre_irq, 1'b0);
    fifo_count = 5'd0;
    @(negedge clk);
    delay_check("R9", frame_n(0, 0));
    wr_pulse();

    // R7: top read on the immediate-set edge
    fifo_count = 5'd2;
    @(negedge clk);
    fifo_count = 5'd0;
    iir_rd = 1'b1; iir_thre_top = 1'b1;
    @(negedge clk);
    iir_rd = 1'b0; iir_thre_top = 1'b0;
    chk("R7", thre_irq, 1'b0);

    // R7: write on the final tick
    empty_after(1);
    repeat (frame_n(0, 0) - 1) tick();
    bit_tick = 1'b1; thr_wr = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; thr_wr = 1'b0;
    chk("R7", thre_irq, 1'b0);
    repeat (4) tick();
    chk("R7", thre_irq, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule